// File: doc/BRIEF.md
# Clock Divider Bank Controller

The block owns a bank of up to sixteen (nine by default) programmable clock dividers that run from a reference clock. Each divider produces a one-cycle clock-enable pulse per output period. Software programs new ratios into shadow registers and marks which outputs must restart together. A single GO command then moves the whole set into the running dividers. The same register file holds a PLL control word with select, reset, power-down and disable bits, plus a multiplier field. A lock counter stands in for the analog lock time before the PLL may be chosen over bypass.

At GO the controller takes a snapshot of every shadow register and of the alignment mask. The transfer state machine has three states. `XS_IDLE` moves to `XS_LOAD` when a GO is accepted. `XS_LOAD` always moves to `XS_SETTLE` one cycle later. `XS_SETTLE` returns to `XS_IDLE` once no divider is waiting to load and every aligned divider has finished its first period.

In `XS_LOAD` all aligned dividers reload at once and restart from phase zero. A non-aligned divider keeps its old ratio until its own period boundary, then switches without a truncated period. The status register shows busy in every state except `XS_IDLE`.

Top module: `clock_divider_bank`

## Requirements
- R1: After reset, the control word reads 0x0A (reset bit 3 and power-down bit 1 set, select bit 0 clear). Status, alignment and every divider register read 0. No tick is driven and `pll_sel` is low.
- R2: A divider register (word address 16+i for divider i) keeps the enable flag in bit 15 and the ratio minus one in bits DIV_W-1:0. Other bits read 0, so a write of 0xFFFF reads back 0x80FF.
- R3: Shadow writes do not change any running divider until a GO is accepted. A shadow write made while busy does not alter the transfer already in progress; the new value waits for the next GO.
- R4: Writing 1 to bit 0 of the command register (address 2) while idle starts a transfer. Status bit 0 (address 3) reads 1 from the first register read sampled after the GO edge.
- R5: A GO written while the status bit is busy is ignored. The running transfer neither restarts nor lengthens.
- R6: A non-aligned divider loads its new ratio at the first period boundary strictly after the GO cycle. A boundary in the GO cycle itself still runs the old ratio for one more full period.
- R7: Dividers whose bit is set in the alignment register (address 4, bit i for divider i) reload in the cycle after GO. All of them pulse their tick together on the second edge after the GO edge.
- R8: With N the largest ratio among the aligned dividers, the status bit reads 1 for reads sampled on edges GO+1 to GO+N+2 and 0 from GO+N+3. This holds when no non-aligned divider is still waiting.
- R9: An enabled divider with ratio field k pulses its tick exactly once every k+1 cycles, so a field of 0 pulses every cycle. A divider loaded with enable 0 never pulses.
- R10: `pll_sel` is high only while control bit 0 is set, bit 4 (disable) is clear and the lock count has finished. `pll_reset`, `pll_powerdown` and `pll_disable` follow bits 3, 1 and 4.
- R11: The lock counter restarts while bit 3 or bit 1 is set. `pll_locked` rises LOCK_CYCLES edges after the write that clears both bits, and falls within two edges after bit 3 is set again.
- R12: The multiplier register (address 1) keeps the 8 low bits of a write, reads them back, and drives them on `pll_mult`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| div_tick | output | NUM_DIV | One-cycle enable pulse per divided period |
| pll_sel | output | 1 | 1 selects PLL output, 0 selects bypass |
| pll_locked | output | 1 | Lock time has elapsed |
| pll_reset | output | 1 | PLL reset request |
| pll_powerdown | output | 1 | PLL power-down request |
| pll_disable | output | 1 | PLL output disable |
| pll_mult | output | MULT_W | Multiplier minus one |

## Verification
The sharpest collision is a GO command landing in the same cycle as a non-aligned divider's period boundary. The bench waits for a tick, counts to the last cycle of that period, and places the GO write exactly on that boundary edge. It then requires one more old-ratio tick before the new spacing begins. The second overlap is a GO that arrives while a transfer is still settling, together with a fresh shadow write. It is judged by reading status on the exact edges where the first transfer must still be busy and then idle, and by measuring that the running period reflects the earlier snapshot.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    localparam int REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] A_CTRL     = 5'd0;
    localparam logic [REG_ADDR_W-1:0] A_MULT     = 5'd1;
    localparam logic [REG_ADDR_W-1:0] A_CMD      = 5'd2;
    localparam logic [REG_ADDR_W-1:0] A_STAT     = 5'd3;
    localparam logic [REG_ADDR_W-1:0] A_ALIGN    = 5'd4;
    localparam logic [REG_ADDR_W-1:0] A_DIV_BASE = 5'd16;

    // control word bit positions
    localparam int CTL_SEL   = 0;
    localparam int CTL_PWRDN = 1;
    localparam int CTL_RST   = 3;
    localparam int CTL_DIS   = 4;
    localparam int CTL_W     = 5;
    localparam logic [CTL_W-1:0] CTL_RESET_VAL = 5'b01010;
    localparam logic [CTL_W-1:0] CTL_WR_MASK   = 5'b11011;

    localparam int DIV_EN_BIT = 15;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_LOAD   = 2'd1,
        XS_SETTLE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/cdb_regfile.sv
module cdb_regfile
    import cdb_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int DIV_W   = 8,
    parameter int MULT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [REG_ADDR_W-1:0]          addr,
    input  logic [31:0]                    wdata,
    input  logic                           busy,
    output logic [31:0]                    rdata,
    output logic                           rvalid,
    output logic                           go_req,
    output logic                           ctl_sel,
    output logic                           ctl_pwrdn,
    output logic                           ctl_rst,
    output logic                           ctl_dis,
    output logic [MULT_W-1:0]              mult,
    output logic [NUM_DIV-1:0]             align,
    output logic [NUM_DIV-1:0]             sh_en,
    output logic [NUM_DIV-1:0][DIV_W-1:0]  sh_div
);
    logic [CTL_W-1:0]               ctrl_q;
    logic [MULT_W-1:0]              mult_q;
    logic [NUM_DIV-1:0]             align_q;
    logic [NUM_DIV-1:0]             sh_en_q;
    logic [NUM_DIV-1:0][DIV_W-1:0]  sh_div_q;
    logic [31:0]                    rd_mux;
    logic                           unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTL_RESET_VAL;
            mult_q  <= '0;
            align_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL)  ctrl_q  <= wdata[CTL_W-1:0] & CTL_WR_MASK;
            if (addr == A_MULT)  mult_q  <= wdata[MULT_W-1:0];
            if (addr == A_ALIGN) align_q <= wdata[NUM_DIV-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_en_q  <= '0;
            sh_div_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (addr == A_DIV_BASE + REG_ADDR_W'(i)) begin
                    sh_en_q[i]  <= wdata[DIV_EN_BIT];
                    sh_div_q[i] <= wdata[DIV_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL:  rd_mux[CTL_W-1:0]   = ctrl_q;
            A_MULT:  rd_mux[MULT_W-1:0]  = mult_q;
            A_STAT:  rd_mux[0]           = busy;
            A_ALIGN: rd_mux[NUM_DIV-1:0] = align_q;
            default: rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_DIV; i++) begin
            if (addr == A_DIV_BASE + REG_ADDR_W'(i)) begin
                rd_mux[DIV_EN_BIT]  = sh_en_q[i];
                rd_mux[DIV_W-1:0]   = sh_div_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

    assign go_req    = wr_en && (addr == A_CMD) && wdata[0];
    assign ctl_sel   = ctrl_q[CTL_SEL];
    assign ctl_pwrdn = ctrl_q[CTL_PWRDN];
    assign ctl_rst   = ctrl_q[CTL_RST];
    assign ctl_dis   = ctrl_q[CTL_DIS];
    assign mult      = mult_q;
    assign align     = align_q;
    assign sh_en     = sh_en_q;
    assign sh_div    = sh_div_q;
endmodule

// File: rtl/cdb_xfer_fsm.sv
module cdb_xfer_fsm
    import cdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic pend_any,
    input  logic settle_any,
    output logic busy,
    output logic capture,
    output logic align_load
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:   if (go_req) state_d = XS_LOAD;
            XS_LOAD:   state_d = XS_SETTLE;
            XS_SETTLE: if (!pend_any && !settle_any) state_d = XS_IDLE;
            default:   state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b1;
        capture    = 1'b0;
        align_load = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                busy    = 1'b0;
                capture = go_req;
            end
            XS_LOAD:   align_load = 1'b1;
            XS_SETTLE: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/cdb_divider.sv
module cdb_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             align_load,
    input  logic             sh_en,
    input  logic [DIV_W-1:0] sh_div,
    input  logic             sh_align,
    output logic             tick,
    output logic             pend,
    output logic             settle,
    output logic             armed
);
    logic             nxt_en, is_al, pend_q, settle_q, act_en;
    logic [DIV_W-1:0] nxt_div, act_div, cnt;
    logic             boundary, load_na, load_al;

    assign boundary = !act_en || (cnt == act_div);
    assign load_na  = pend_q && boundary;
    assign load_al  = align_load && is_al;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_en   <= 1'b0;
            nxt_div  <= '0;
            is_al    <= 1'b0;
            pend_q   <= 1'b0;
            settle_q <= 1'b0;
            act_en   <= 1'b0;
            act_div  <= '0;
            cnt      <= '0;
        end else begin
            if (capture) begin
                nxt_en  <= sh_en;
                nxt_div <= sh_div;
                is_al   <= sh_align;
                pend_q  <= !sh_align;
            end
            if (load_na || load_al) begin
                act_en   <= nxt_en;
                act_div  <= nxt_div;
                cnt      <= '0;
                pend_q   <= 1'b0;
                settle_q <= load_al && nxt_en;
            end else begin
                if (act_en) cnt <= (cnt == act_div) ? '0 : cnt + 1'b1;
                if (settle_q && act_en && (cnt == act_div)) settle_q <= 1'b0;
            end
        end
    end

    assign tick   = act_en && (cnt == '0);
    assign pend   = pend_q;
    assign settle = settle_q;
    assign armed  = is_al && nxt_en;
endmodule

// File: rtl/cdb_lock.sv
module cdb_lock #(
    parameter int LOCK_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (hold)           cnt <= '0;
        else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
    end

    assign locked = (cnt == LIMIT);
endmodule

// File: rtl/clock_divider_bank.sv
module clock_divider_bank
    import cdb_pkg::*;
#(
    parameter int NUM_DIV     = 9,
    parameter int DIV_W       = 8,
    parameter int MULT_W      = 8,
    parameter int LOCK_CYCLES = 8000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [4:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  reg_rvalid,
    output logic [NUM_DIV-1:0]    div_tick,
    output logic                  pll_sel,
    output logic                  pll_locked,
    output logic                  pll_reset,
    output logic                  pll_powerdown,
    output logic                  pll_disable,
    output logic [MULT_W-1:0]     pll_mult
);
    logic                          busy, go_req, capture, align_load;
    logic                          ctl_sel, ctl_pwrdn, ctl_rst, ctl_dis;
    logic [NUM_DIV-1:0]            align, sh_en;
    logic [NUM_DIV-1:0][DIV_W-1:0] sh_div;
    logic [NUM_DIV-1:0]            pend_vec, settle_vec, armed_vec;

    cdb_regfile #(.NUM_DIV(NUM_DIV), .DIV_W(DIV_W), .MULT_W(MULT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .busy(busy),
        .rdata(reg_rdata), .rvalid(reg_rvalid), .go_req(go_req),
        .ctl_sel(ctl_sel), .ctl_pwrdn(ctl_pwrdn), .ctl_rst(ctl_rst), .ctl_dis(ctl_dis),
        .mult(pll_mult), .align(align), .sh_en(sh_en), .sh_div(sh_div)
    );

    cdb_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req),
        .pend_any(|pend_vec), .settle_any(|settle_vec),
        .busy(busy), .capture(capture), .align_load(align_load)
    );

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        cdb_divider #(.DIV_W(DIV_W)) u_div (
            .clk(clk), .rst_n(rst_n), .capture(capture), .align_load(align_load),
            .sh_en(sh_en[i]), .sh_div(sh_div[i]), .sh_align(align[i]),
            .tick(div_tick[i]), .pend(pend_vec[i]), .settle(settle_vec[i]),
            .armed(armed_vec[i])
        );
    end

    cdb_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .hold(ctl_rst || ctl_pwrdn), .locked(pll_locked)
    );

    assign pll_sel       = ctl_sel && pll_locked && !ctl_dis;
    assign pll_reset     = ctl_rst;
    assign pll_powerdown = ctl_pwrdn;
    assign pll_disable   = ctl_dis;
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker
    import cdb_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int MULT_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               go_req,
    input logic               capture,
    input logic               align_load,
    input logic [NUM_DIV-1:0] div_tick,
    input logic [NUM_DIV-1:0] armed_vec,
    input logic [NUM_DIV-1:0] pend_vec,
    input logic [NUM_DIV-1:0] settle_vec,
    input logic               pll_reset,
    input logic               pll_locked,
    input logic [MULT_W-1:0]  pll_mult,
    input logic               reg_wr,
    input logic [4:0]         reg_addr
);
    p_go_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> busy);

    p_go_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req) |=> !align_load);

    p_aligned_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_load |=> ((div_tick & armed_vec) == armed_vec));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pend_vec == '0 && settle_vec == '0));

    p_lock_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset |=> !pll_locked);

    p_mult_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_MULT) |=> $stable(pll_mult));
endmodule

bind clock_divider_bank cdb_checker #(.NUM_DIV(NUM_DIV), .MULT_W(MULT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .go_req(go_req), .capture(capture),
    .align_load(align_load), .div_tick(div_tick), .armed_vec(armed_vec),
    .pend_vec(pend_vec), .settle_vec(settle_vec), .pll_reset(pll_reset),
    .pll_locked(pll_locked), .pll_mult(pll_mult), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/clock_divider_bank_test.sv
`timescale 1ns/1ps
module clock_divider_bank_test;
    localparam int NUM_DIV = 9;
    localparam int LOCK    = 8000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic reg_rvalid, pll_sel, pll_locked, pll_reset, pll_powerdown, pll_disable;
    logic [NUM_DIV-1:0] div_tick;
    logic [7:0] pll_mult;

    int compared = 0, mismatched = 0;
    int cyc = 0;

    typedef struct { string tag; logic [31:0] exp; } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clock_divider_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .div_tick(div_tick), .pll_sel(pll_sel),
        .pll_locked(pll_locked), .pll_reset(pll_reset), .pll_powerdown(pll_powerdown),
        .pll_disable(pll_disable), .pll_mult(pll_mult)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each returned read with the queued expectation
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (sb_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R4 unexpected read data actual=%0h expected=none", reg_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        sb_q.push_back('{tag, exp});
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick_gap(input int i, output int gap);
        int t1;
        do @(negedge clk); while (!div_tick[i]);
        t1 = cyc;
        do @(negedge clk); while (!div_tick[i]);
        gap = cyc - t1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL R4 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int g, t0, hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ticks", 32'(div_tick), 0);
        check("R1 pll_sel", 32'(pll_sel), 0);
        rd_chk(5'd0, 32'h0A, "R1 ctrl");
        rd_chk(5'd3, 32'h0, "R1 status");
        rd_chk(5'd4, 32'h0, "R1 align");
        rd_chk(5'd16, 32'h0, "R1 div0");

        // R2 register format
        wr(5'd16, 32'h8003);
        wr(5'd17, 32'h8000);
        wr(5'd18, 32'h8005);
        wr(5'd19, 32'hFFFF);
        rd_chk(5'd16, 32'h8003, "R2 div0 readback");
        rd_chk(5'd19, 32'h80FF, "R2 masked readback");
        wr(5'd19, 32'h0);

        // R3 no effect before GO
        hits = 0;
        for (int k = 0; k < 6; k++) begin @(negedge clk); if (div_tick != '0) hits++; end
        check("R3 no ticks before GO", hits, 0);

        // R4 R7 R8 aligned transfer, max ratio 6
        wr(5'd4, 32'h7);
        wr(5'd2, 32'h1);
        for (int k = 1; k <= 10; k++) begin
            rd_chk(5'd3, (k <= 8) ? 32'h1 : 32'h0, "R8 R4 status poll");
            if (k == 1) check("R7 aligned ticks together", 32'(div_tick), 32'h7);
        end
        tick_gap(0, g); check("R9 div0 period", g, 4);
        tick_gap(1, g); check("R9 zero ratio every cycle", g, 1);
        tick_gap(2, g); check("R9 div2 period", g, 6);

        // R5 GO while busy ignored; R3 shadow write during transfer
        wr(5'd16, 32'h8007);
        wr(5'd4, 32'h1);
        wr(5'd2, 32'h1);
        wr(5'd16, 32'h8001);
        wr(5'd2, 32'h1);
        repeat (7) @(negedge clk);
        rd_chk(5'd3, 32'h1, "R5 still busy from first GO");
        rd_chk(5'd3, 32'h0, "R5 idle after first transfer only");
        tick_gap(0, g); check("R3 snapshot kept during busy", g, 8);
        wr(5'd2, 32'h1);
        repeat (15) @(negedge clk);
        tick_gap(0, g); check("R3 later shadow applied at next GO", g, 2);

        // R6 GO on a non-aligned boundary
        wr(5'd4, 32'h0);
        wr(5'd18, 32'h8002);
        repeat (10) @(negedge clk);
        do @(negedge clk); while (!div_tick[2]);
        t0 = cyc;
        repeat (5) @(negedge clk);
        wr(5'd2, 32'h1);
        check("R6 old period tick at GO boundary", 32'(div_tick[2]), 1);
        do @(negedge clk); while (!div_tick[2]);
        check("R6 old ratio runs one more period", cyc - t0, 12);
        do @(negedge clk); while (!div_tick[2]);
        check("R6 new ratio after load", cyc - t0, 15);

        // R9 disabled divider
        wr(5'd17, 32'h0);
        wr(5'd2, 32'h1);
        repeat (10) @(negedge clk);
        hits = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (div_tick[1]) hits++; end
        check("R9 disabled output silent", hits, 0);

        // R12 multiplier
        wr(5'd1, 32'h3C5);
        check("R12 pll_mult", 32'(pll_mult), 32'hC5);
        rd_chk(5'd1, 32'hC5, "R12 mult readback");

        // R10 R11 control and lock
        check("R10 reset pin", 32'(pll_reset), 1);
        check("R10 powerdown pin", 32'(pll_powerdown), 1);
        wr(5'd0, 32'h01);
        check("R10 reset released", 32'(pll_reset), 0);
        repeat (LOCK - 1) @(negedge clk);
        check("R11 not locked early", {pll_locked, pll_sel}, 0);
        @(negedge clk);
        check("R11 R10 locked and selected", {pll_locked, pll_sel}, 3);
        wr(5'd0, 32'h11);
        check("R10 disable forces bypass", {pll_disable, pll_sel}, 2);
        wr(5'd0, 32'h00);
        check("R10 bypass when select clear", {pll_locked, pll_sel}, 2);
        wr(5'd0, 32'h09);
        @(negedge clk);
        check("R11 lock lost on reset", {pll_reset, pll_locked}, 2);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule